// File: doc/BRIEF.md
# Post-Increment Load/Store Address Unit

This block sits in one stage of a 64-bit load/store pipeline. It runs loads and stores whose base-register update happens after the memory access, not before it. An operation arrives with the following fields:
- an opcode and a form bit (immediate or indexed);
- the current base register value;
- an index value, a 16-bit displacement and store source data;
- two register numbers, one for the destination and one for the base.

The block sends the memory request to the unmodified base address. For loads it shapes the returned data into a destination value, using zero or sign extension. It then writes the updated base (base plus displacement, or base plus index) back to the register file. It handles one operation at a time.

The operation input is valid/ready. `op_ready` is high only while the unit is idle, and an operation is taken on a clock edge where `op_valid` and `op_ready` are both high. The memory request is valid/ready. Once `mem_req_valid` is raised, it stays high with the address, enables and data held stable until `mem_req_ready` is seen. The memory response has no back-pressure: the unit accepts `mem_rsp_valid` in any cycle in which it waits for load data. The two write-back ports and the error flag are single-cycle pulses that the register file always accepts.

Top module: `pinc_lsu`

## Requirements
- R1: The memory address `mem_addr` of every request equals the base value `op_base` supplied with the operation, with no offset added.
- R2: For the immediate form (`op_indexed`=0), the base write-back value is `op_base` plus the 16-bit `op_disp` sign-extended to 64 bits, written to register `op_ra`.
- R3: For the indexed form (`op_indexed`=1), the base write-back value is `op_base` plus `op_index`.
- R4: For the doubleword immediate forms (codes 5 and 9), bits 1:0 of `op_disp` are treated as zero before sign extension. Other sizes use all 16 displacement bits.
- R5: The zero-extending loads fill all bits above the loaded size with zeros. These are codes 0 (byte), 1 (halfword) and 3 (word). Code 5 (doubleword) takes all 64 bits unchanged. Load data sits in the low bytes of `mem_rsp_data`.
- R6: The sign-extending loads copy the top bit of the loaded value into all 64 bits. These are codes 2 (halfword) and 4 (word).
- R7: A load pulses `wb_dst_valid` (register `op_rd`) and `wb_base_valid` together in the same cycle. A store pulses only `wb_base_valid`.
- R8: Stores use codes 6 (byte), 7 (halfword), 8 (word) and 9 (doubleword) and drive `mem_we`=1. For these, `mem_be` enables the lowest 1, 2, 4 or 8 byte lanes. `mem_wdata` carries the matching low bytes of `op_src`, with the disabled lanes zero. Loads drive `mem_we`=0 with the same lane enables.
- R9: The unit flags an operation as invalid in two cases: a load whose `op_rd` equals `op_ra`, and an opcode of 10 to 15. An invalid operation produces a one-cycle `op_err` pulse, no memory request and no write-back. A store with equal `op_rd` and `op_ra` is valid.
- R10: The base write-back happens only after the memory request handshake completes. While `mem_req_ready` is low, the request stays asserted with a stable address and no write-back occurs.
- R11: `op_ready` is low from the cycle after an operation is accepted until the unit returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation accepted this cycle if valid |
| op_code | input | 4 | Opcode: 0 byte-zero, 1 half-zero, 2 half-signed, 3 word-zero, 4 word-signed, 5 double load; 6..9 byte/half/word/double store |
| op_indexed | input | 1 | 1 = indexed form, 0 = immediate form |
| op_base | input | 64 | Current base register value |
| op_index | input | 64 | Index register value |
| op_disp | input | 16 | Signed displacement |
| op_src | input | 64 | Store source register value |
| op_rd | input | 5 | Load destination register number |
| op_ra | input | 5 | Base register number |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_addr | output | 64 | Effective address |
| mem_we | output | 1 | 1 = write |
| mem_be | output | 8 | Byte lane enables |
| mem_wdata | output | 64 | Store data |
| mem_rsp_valid | input | 1 | Load data returned |
| mem_rsp_data | input | 64 | Load data, low-aligned |
| wb_dst_valid | output | 1 | Destination write pulse |
| wb_dst_idx | output | 5 | Destination register number |
| wb_dst_data | output | 64 | Formatted load result |
| wb_base_valid | output | 1 | Base write pulse |
| wb_base_idx | output | 5 | Base register number |
| wb_base_data | output | 64 | Updated base value |
| op_err | output | 1 | Invalid operation pulse |

## Verification
For a load, the destination write and the base write fall in the same cycle, on different ports. Every load scenario samples both ports on the one clock where they pulse and compares each value and register number against its own expectation. The bench also provokes the case where a base update is due while memory holds off the request, by keeping `mem_req_ready` low for several cycles. It then judges that the address stays fixed, that no base write appears during the stall, and that the base write arrives only after the handshake.

// File: rtl/pinc_pkg.sv
package pinc_pkg;
  typedef enum logic [3:0] {
    OP_LBZ = 4'd0,
    OP_LHZ = 4'd1,
    OP_LHA = 4'd2,
    OP_LWZ = 4'd3,
    OP_LWA = 4'd4,
    OP_LD  = 4'd5,
    OP_SB  = 4'd6,
    OP_SH  = 4'd7,
    OP_SW  = 4'd8,
    OP_SD  = 4'd9
  } pinc_op_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } pinc_size_e;

  typedef struct packed {
    logic       legal;
    logic       is_load;
    logic       sext;
    pinc_size_e size;
  } pinc_dec_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_RSP  = 3'd2,
    ST_WB   = 3'd3,
    ST_ERR  = 3'd4
  } pinc_state_e;
endpackage

// File: rtl/pinc_decode.sv
module pinc_decode
  import pinc_pkg::*;
(
  input  logic [3:0] code,
  output pinc_dec_t  dec
);
  always_comb begin
    dec = '{legal: 1'b1, is_load: 1'b1, sext: 1'b0, size: SZ_B};
    case (code)
      OP_LBZ: dec.size = SZ_B;
      OP_LHZ: dec.size = SZ_H;
      OP_LHA: begin dec.size = SZ_H; dec.sext = 1'b1; end
      OP_LWZ: dec.size = SZ_W;
      OP_LWA: begin dec.size = SZ_W; dec.sext = 1'b1; end
      OP_LD:  dec.size = SZ_D;
      OP_SB:  begin dec.size = SZ_B; dec.is_load = 1'b0; end
      OP_SH:  begin dec.size = SZ_H; dec.is_load = 1'b0; end
      OP_SW:  begin dec.size = SZ_W; dec.is_load = 1'b0; end
      OP_SD:  begin dec.size = SZ_D; dec.is_load = 1'b0; end
      default: begin dec.legal = 1'b0; dec.is_load = 1'b0; end
    endcase
  end
endmodule

// File: rtl/pinc_agen.sv
module pinc_agen
  import pinc_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int DISP_W = 16
) (
  input  logic [XLEN-1:0]   base,
  input  logic [XLEN-1:0]   index,
  input  logic [DISP_W-1:0] disp,
  input  logic              indexed,
  input  pinc_size_e        size,
  output logic [XLEN-1:0]   new_base
);
  logic [DISP_W-1:0] disp_eff;
  logic [XLEN-1:0]   offset;

  always_comb begin
    disp_eff = disp;
    if (size == SZ_D) disp_eff[1:0] = 2'b00;
    offset   = indexed ? index : {{(XLEN-DISP_W){disp_eff[DISP_W-1]}}, disp_eff};
    new_base = base + offset;
  end
endmodule

// File: rtl/pinc_lanes.sv
module pinc_lanes
  import pinc_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int NB  = XLEN / 8
) (
  input  pinc_size_e      size,
  input  logic            is_store,
  input  logic [XLEN-1:0] src,
  output logic [NB-1:0]   be,
  output logic [XLEN-1:0] wdata
);
  logic [3:0] nbytes;
  assign nbytes = 4'd1 << size;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign be[i]           = (i < nbytes);
    assign wdata[i*8 +: 8] = (be[i] && is_store) ? src[i*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/pinc_fmt.sv
module pinc_fmt
  import pinc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] raw,
  input  pinc_size_e      size,
  input  logic            sext,
  output logic [XLEN-1:0] result
);
  always_comb begin
    case (size)
      SZ_B: result = {{(XLEN-8){sext & raw[7]}}, raw[7:0]};
      SZ_H: result = {{(XLEN-16){sext & raw[15]}}, raw[15:0]};
      SZ_W: result = {{(XLEN-32){sext & raw[31]}}, raw[31:0]};
      default: result = raw;
    endcase
  end
endmodule

// File: rtl/pinc_lsu.sv
module pinc_lsu
  import pinc_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int DISP_W = 16,
  parameter int REG_AW = 5,
  localparam int NB    = XLEN / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [3:0]        op_code,
  input  logic              op_indexed,
  input  logic [XLEN-1:0]   op_base,
  input  logic [XLEN-1:0]   op_index,
  input  logic [DISP_W-1:0] op_disp,
  input  logic [XLEN-1:0]   op_src,
  input  logic [REG_AW-1:0] op_rd,
  input  logic [REG_AW-1:0] op_ra,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_addr,
  output logic              mem_we,
  output logic [NB-1:0]     mem_be,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [XLEN-1:0]   mem_rsp_data,
  output logic              wb_dst_valid,
  output logic [REG_AW-1:0] wb_dst_idx,
  output logic [XLEN-1:0]   wb_dst_data,
  output logic              wb_base_valid,
  output logic [REG_AW-1:0] wb_base_idx,
  output logic [XLEN-1:0]   wb_base_data,
  output logic              op_err
);
  pinc_state_e       state;
  pinc_dec_t         dec_in, r_dec;
  logic [XLEN-1:0]   nb_in, be_wd_in;
  logic [NB-1:0]     be_in;
  logic [XLEN-1:0]   r_base, r_newbase, r_wdata, r_rdata;
  logic [NB-1:0]     r_be;
  logic [REG_AW-1:0] r_rd, r_ra;
  logic              accept, bad_op;

  pinc_decode u_dec (.code(op_code), .dec(dec_in));

  pinc_agen #(.XLEN(XLEN), .DISP_W(DISP_W)) u_agen (
    .base(op_base), .index(op_index), .disp(op_disp),
    .indexed(op_indexed), .size(dec_in.size), .new_base(nb_in)
  );

  pinc_lanes #(.XLEN(XLEN)) u_lanes (
    .size(dec_in.size), .is_store(!dec_in.is_load), .src(op_src),
    .be(be_in), .wdata(be_wd_in)
  );

  pinc_fmt #(.XLEN(XLEN)) u_fmt (
    .raw(r_rdata), .size(r_dec.size), .sext(r_dec.sext), .result(wb_dst_data)
  );

  assign op_ready = (state == ST_IDLE);
  assign accept   = op_valid && op_ready;
  assign bad_op   = !dec_in.legal || (dec_in.is_load && (op_rd == op_ra));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      r_dec     <= '0;
      r_base    <= '0;
      r_newbase <= '0;
      r_wdata   <= '0;
      r_rdata   <= '0;
      r_be      <= '0;
      r_rd      <= '0;
      r_ra      <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          r_dec     <= dec_in;
          r_base    <= op_base;
          r_newbase <= nb_in;
          r_wdata   <= be_wd_in;
          r_be      <= be_in;
          r_rd      <= op_rd;
          r_ra      <= op_ra;
          state     <= bad_op ? ST_ERR : ST_REQ;
        end
        ST_REQ: if (mem_req_ready) state <= r_dec.is_load ? ST_RSP : ST_WB;
        ST_RSP: if (mem_rsp_valid) begin
          r_rdata <= mem_rsp_data;
          state   <= ST_WB;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state == ST_REQ);
  assign mem_addr      = r_base;
  assign mem_we        = !r_dec.is_load;
  assign mem_be        = r_be;
  assign mem_wdata     = r_wdata;
  assign wb_base_valid = (state == ST_WB);
  assign wb_base_idx   = r_ra;
  assign wb_base_data  = r_newbase;
  assign wb_dst_valid  = (state == ST_WB) && r_dec.is_load;
  assign wb_dst_idx    = r_rd;
  assign op_err        = (state == ST_ERR);
endmodule

// File: rtl/pinc_lsu_chk.sv
module pinc_lsu_chk #(
  parameter int XLEN   = 64,
  parameter int REG_AW = 5,
  localparam int NB    = XLEN / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [XLEN-1:0]   mem_addr,
  input logic [NB-1:0]     mem_be,
  input logic              wb_dst_valid,
  input logic [REG_AW-1:0] wb_dst_idx,
  input logic              wb_base_valid,
  input logic [REG_AW-1:0] wb_base_idx,
  input logic              op_err
);
  logic hs_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hs_seen <= 1'b0;
    else if (mem_req_valid && mem_req_ready) hs_seen <= 1'b1;
    else if (wb_base_valid) hs_seen <= 1'b0;
  end

  // R10
  base_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_base_valid |-> hs_seen);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));

  // R7
  dst_with_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_dst_valid |-> wb_base_valid);

  // R9
  dst_ne_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_dst_valid |-> (wb_dst_idx != wb_base_idx));

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |-> (!wb_base_valid && !wb_dst_valid && !mem_req_valid));

  // R8
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_be[0] && ($countones(mem_be) == 1 || $countones(mem_be) == 2
                       || $countones(mem_be) == 4 || $countones(mem_be) == 8)));

  // R11
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || wb_base_valid || op_err) |-> !op_ready);
endmodule

bind pinc_lsu pinc_lsu_chk #(.XLEN(XLEN), .REG_AW(REG_AW)) u_chk (.*);

// File: tb/tb_pinc_lsu.sv
`timescale 1ns/1ps
module tb_pinc_lsu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [3:0]  op_code = '0;
  logic        op_indexed = 1'b0;
  logic [63:0] op_base = '0, op_index = '0, op_src = '0;
  logic [15:0] op_disp = '0;
  logic [4:0]  op_rd = '0, op_ra = '0;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [63:0] mem_addr, mem_wdata;
  logic        mem_we;
  logic [7:0]  mem_be;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        wb_dst_valid, wb_base_valid, op_err;
  logic [4:0]  wb_dst_idx, wb_base_idx;
  logic [63:0] wb_dst_data, wb_base_data;

  int total = 0;
  int bad = 0;

  // observations of the last operation
  logic [63:0] o_addr, o_wdata, o_dst, o_nbase;
  logic [7:0]  o_be;
  logic        o_we, o_err, o_dstv, o_basev, o_unstable, o_early, o_busyrdy;
  logic [4:0]  o_dsti, o_basei;
  int          o_reqs, o_stalls;

  always #2.5 clk = ~clk;

  pinc_lsu dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] code, input logic idx, input logic [63:0] base,
                        input logic [63:0] index, input logic [15:0] disp, input logic [63:0] src,
                        input logic [4:0] rd, input logic [4:0] ra, input int stall,
                        input logic [63:0] rdata);
    bit done = 0, req_done = 0, rsp_sent = 0, first = 1;
    o_reqs = 0; o_stalls = 0; o_unstable = 0; o_early = 0; o_busyrdy = 0;
    o_err = 0; o_dstv = 0; o_basev = 0; o_addr = '0; o_we = 0; o_be = '0; o_wdata = '0;
    @(negedge clk);
    op_code = code; op_indexed = idx; op_base = base; op_index = index;
    op_disp = disp; op_src = src; op_rd = rd; op_ra = ra; op_valid = 1'b1;
    @(posedge clk);
    #1 op_valid = 1'b0;
    for (int c = 0; c < 40 && !done; c++) begin
      @(negedge clk);
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      if (op_ready) o_busyrdy = 1;
      if (wb_base_valid || op_err || wb_dst_valid) begin
        done = 1;
        if (!req_done && !op_err) o_early = 1;
        o_err = op_err; o_dstv = wb_dst_valid; o_basev = wb_base_valid;
        o_dst = wb_dst_data; o_dsti = wb_dst_idx; o_nbase = wb_base_data; o_basei = wb_base_idx;
      end else if (mem_req_valid) begin
        if (first) begin
          o_addr = mem_addr; o_we = mem_we; o_be = mem_be; o_wdata = mem_wdata; first = 0;
        end else if (mem_addr !== o_addr) o_unstable = 1;
        if (o_stalls < stall) o_stalls++;
        else begin mem_req_ready = 1'b1; req_done = 1; o_reqs++; end
      end else if (req_done && !rsp_sent && !o_we) begin
        mem_rsp_valid = 1'b1; mem_rsp_data = rdata; rsp_sent = 1;
      end
    end
    @(negedge clk);
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R11 reset op_ready", op_ready, 1);
    check("R10 reset mem_req_valid", mem_req_valid, 0);
    check("R7 reset wb valids", {wb_dst_valid, wb_base_valid, op_err}, 0);
  endtask

  task automatic t_lbz_imm;
    run_op(4'd0, 0, 64'h1000, 0, 16'hFFFC, 0, 5'd2, 5'd1, 0, 64'hFFFF_FF80);
    check("R1 lbz addr", o_addr, 64'h1000);
    check("R2 lbz new base", o_nbase, 64'hFFC);
    check("R2 base idx", o_basei, 5'd1);
    check("R5 lbz zero ext", o_dst, 64'h80);
    check("R7 load both ports", {o_dstv, o_basev}, 2'b11);
    check("R7 dst idx", o_dsti, 5'd2);
    check("R8 load be/we", {o_we, o_be}, {1'b0, 8'h01});
    check("R11 busy not ready", o_busyrdy, 0);
  endtask

  task automatic t_half;
    run_op(4'd2, 1, 64'h2000, 64'h30, 0, 0, 5'd4, 5'd5, 0, 64'h1234_8001);
    check("R3 lha indexed new base", o_nbase, 64'h2030);
    check("R6 lha sign ext", o_dst, 64'hFFFF_FFFF_FFFF_8001);
    check("R8 half be", o_be, 8'h03);
    run_op(4'd1, 1, 64'h2000, 64'h30, 0, 0, 5'd4, 5'd5, 0, 64'h1234_8001);
    check("R5 lhz zero ext", o_dst, 64'h8001);
  endtask

  task automatic t_word;
    run_op(4'd4, 0, 64'h100, 0, 16'h0008, 0, 5'd6, 5'd7, 0, 64'hAAAA_AAAA_8000_0000);
    check("R6 lwa sign ext", o_dst, 64'hFFFF_FFFF_8000_0000);
    check("R2 lwa new base", o_nbase, 64'h108);
    check("R8 word be", o_be, 8'h0F);
    run_op(4'd3, 0, 64'h100, 0, 16'h0008, 0, 5'd6, 5'd7, 0, 64'hAAAA_AAAA_8000_0000);
    check("R5 lwz zero ext", o_dst, 64'h8000_0000);
  endtask

  task automatic t_double;
    run_op(4'd5, 0, 64'h4000, 0, 16'h0007, 0, 5'd8, 5'd9, 0, 64'h0123_4567_89AB_CDEF);
    check("R4 ld disp low bits dropped", o_nbase, 64'h4004);
    check("R5 ld full value", o_dst, 64'h0123_4567_89AB_CDEF);
    check("R1 ld addr", o_addr, 64'h4000);
    run_op(4'd5, 0, 64'h4000, 0, 16'hFFF9, 0, 5'd8, 5'd9, 0, 64'h0);
    check("R4 ld negative disp", o_nbase, 64'h3FF8);
    run_op(4'd3, 0, 64'h4000, 0, 16'h0007, 0, 5'd8, 5'd9, 0, 64'h0);
    check("R4 word keeps low disp bits", o_nbase, 64'h4007);
  endtask

  task automatic t_store;
    run_op(4'd8, 1, 64'h5000, 64'hFFFF_FFFF_FFFF_FFF0, 0, 64'h1122_3344_5566_7788, 5'd3, 5'd3, 0, 0);
    check("R8 sw we/be", {o_we, o_be}, {1'b1, 8'h0F});
    check("R8 sw wdata", o_wdata, 64'h5566_7788);
    check("R3 sw new base", o_nbase, 64'h4FF0);
    check("R7 store base only", {o_dstv, o_basev, o_err}, 3'b010);
    check("R1 sw addr", o_addr, 64'h5000);
    run_op(4'd6, 0, 64'h5000, 0, 16'h0001, 64'h1122_3344_5566_7788, 5'd0, 5'd3, 0, 0);
    check("R8 sb be/wdata", {o_be, o_wdata}, {8'h01, 64'h88});
    check("R2 sb new base", o_nbase, 64'h5001);
    run_op(4'd7, 0, 64'h5000, 0, 16'h0002, 64'h1122_3344_5566_7788, 5'd0, 5'd3, 0, 0);
    check("R8 sh be/wdata", {o_be, o_wdata}, {8'h03, 64'h7788});
    run_op(4'd9, 0, 64'h5000, 0, 16'h0008, 64'h1122_3344_5566_7788, 5'd0, 5'd3, 0, 0);
    check("R8 sd be/wdata", {o_be, o_wdata}, {8'hFF, 64'h1122_3344_5566_7788});
    check("R4 sd new base", o_nbase, 64'h5008);
  endtask

  task automatic t_invalid;
    run_op(4'd0, 0, 64'h6000, 0, 16'h0004, 0, 5'd3, 5'd3, 0, 64'hFF);
    check("R9 same reg err", o_err, 1);
    check("R9 same reg no request", o_reqs, 0);
    check("R9 same reg no write", {o_dstv, o_basev}, 2'b00);
    check("R11 ready after err", op_ready, 1);
    run_op(4'd12, 0, 64'h6000, 0, 16'h0004, 0, 5'd1, 5'd2, 0, 0);
    check("R9 undefined code err", {o_err, o_basev}, 2'b10);
    check("R9 undefined code no request", o_reqs, 0);
  endtask

  task automatic t_stall;
    run_op(4'd1, 0, 64'h7000, 0, 16'h0010, 0, 5'd10, 5'd11, 3, 64'hBEEF);
    check("R10 stall cycles seen", o_stalls, 3);
    check("R10 addr stable in stall", o_unstable, 0);
    check("R10 no base write before handshake", o_early, 0);
    check("R10 base after stall", o_nbase, 64'h7010);
    check("R7 dst after stall", {o_dstv, o_basev, o_dst}, {2'b11, 64'hBEEF});
    check("R11 busy not ready in stall", o_busyrdy, 0);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lbz_imm();
    t_half();
    t_word();
    t_double();
    t_store();
    t_invalid();
    t_stall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule